// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block watches three digital supply flags for a battery-backed memory and decides, cycle by cycle, whether the memory may be accessed and whether it runs from the battery. Each flag is 1 while the supply is above its threshold: `aboveHi` for the upper deselect threshold, `aboveLo` for the lower deselect threshold and `aboveSw` for the battery switchover threshold. The flags arrive from analog comparators in another clock domain, so each one passes through a two-stage synchroniser before the state machine uses it.

When the supply sinks into the window between the two deselect thresholds, the block raises `memProtect` after a bounded filter delay of `DESEL_DELAY` cycles. Below the lower threshold it protects at once, and below the switchover threshold it also raises `battSelect`. Protection is released only after the supply has stayed above the upper threshold for `REC_CYCLES` consecutive cycles. Any new drop restarts that wait. After reset the block protects the memory and keeps the battery off until the synchronisers hold valid samples.

Top module: `pwr_fail_guard`

## Requirements
- R1: While reset is held, and until the third rising edge after reset is released, `memProtect` is 1 and `battSelect` is 0.
- R2: A flag change driven before rising edge k affects the state on edge k+2 and not earlier, because of a two-stage synchroniser.
- R3: The supply is in the window when aboveHi=0, aboveLo=1 and aboveSw=1. In normal operation, `memProtect` rises after `DESEL_DELAY` consecutive synchronised window cycles. A window dip that lasts fewer cycles leaves it at 0.
- R4: A synchronised aboveLo=0 with aboveSw=1 sets `memProtect` to 1 on that same edge, without a filter delay.
- R5: A synchronised aboveSw=0 sets `battSelect` and `memProtect` to 1 on that edge. Once aboveSw returns to 1, `battSelect` falls on the edge where that value is first seen.
- R6: `memProtect` falls only after `REC_CYCLES` consecutive synchronised cycles with all flags at 1. Any lower level in between restarts the count from zero.
- R7: Flag combinations that are not consistent are resolved to the lowest level they indicate. For example, 1/0/1 (hi/lo/sw) counts as below the lower threshold, and 1/1/0 counts as below the switchover threshold.
- R8: `battSelect` is never 1 while `memProtect` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| aboveHi | input | 1 | Supply is above the upper deselect threshold (asynchronous) |
| aboveLo | input | 1 | Supply is above the lower deselect threshold (asynchronous) |
| aboveSw | input | 1 | Supply is above the battery switchover threshold (asynchronous) |
| memProtect | output | 1 | Memory is deselected and write-protected |
| battSelect | output | 1 | Memory is powered from the battery |

## Verification
A wrong state shows up directly at the two outputs, since both are decoded from the state register. If the state machine wrongly sits in normal operation, protection is missing three edges after a drop. If it wrongly sits in recovery or protection, the release comes early, late or never. A wrong recovery or filter counter changes the edge on which `memProtect` falls or rises, so the bench compares both outputs on every cycle against a behavioural model that delays the flags by two edges. A one-cycle shift in any count is therefore caught at once.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  // supply level, lowest first
  typedef enum logic [1:0] {LV_BATT, LV_LOW, LV_WIN, LV_OK} level_t;
  typedef enum logic [1:0] {ST_NORMAL, ST_PROTECT, ST_BATTERY, ST_RECOVER} state_t;
  typedef struct packed {
    logic recClr;
    logic recInc;
    logic winClr;
    logic winInc;
  } strobe_t;
endpackage

// File: rtl/pfg_datapath.sv
module pfg_datapath
  import pfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REC_CYCLES  = 1000,
  parameter int DESEL_DELAY = 50
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    aboveHi,
  input  logic    aboveLo,
  input  logic    aboveSw,
  input  strobe_t stb,
  output level_t  level,
  output logic    flagsValid,
  output logic    recDone,
  output logic    winDone
);
  localparam int REC_W = $clog2(REC_CYCLES + 1);
  localparam int WIN_W = $clog2(DESEL_DELAY + 1);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(REC_CYCLES - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(DESEL_DELAY - 1);

  logic [SYNC_STAGES-1:0][2:0] syncPipe;
  logic [SYNC_STAGES-1:0]      fillSr;
  logic [REC_W-1:0]            recCnt;
  logic [WIN_W-1:0]            winCnt;
  logic [2:0]                  flagsS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
      fillSr   <= '0;
    end else begin
      syncPipe[0] <= {aboveHi, aboveLo, aboveSw};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
      fillSr <= {fillSr[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign flagsS     = syncPipe[SYNC_STAGES-1];
  assign flagsValid = fillSr[SYNC_STAGES-1];

  // lowest indicated level wins
  always_comb begin
    if (!flagsS[0])      level = LV_BATT;
    else if (!flagsS[1]) level = LV_LOW;
    else if (!flagsS[2]) level = LV_WIN;
    else                 level = LV_OK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCnt <= '0;
      winCnt <= '0;
    end else begin
      if (stb.recClr)      recCnt <= '0;
      else if (stb.recInc) recCnt <= recCnt + 1'b1;
      if (stb.winClr)      winCnt <= '0;
      else if (stb.winInc) winCnt <= winCnt + 1'b1;
    end
  end

  assign recDone = (recCnt == REC_LAST);
  assign winDone = (winCnt == WIN_LAST);

  p_win_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WIN_LAST);
  p_rec_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    recCnt <= REC_LAST);
endmodule

// File: rtl/pfg_control.sv
module pfg_control
  import pfg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  level_t  level,
  input  logic    flagsValid,
  input  logic    recDone,
  input  logic    winDone,
  output strobe_t stb,
  output logic    protectOut,
  output logic    battOut
);
  state_t state, stateNext;

  always_comb begin
    stateNext  = state;
    stb        = '0;
    stb.recClr = 1'b1;
    stb.winClr = 1'b1;
    if (flagsValid) begin
      unique case (state)
        ST_NORMAL: begin
          unique case (level)
            LV_OK:   stateNext = ST_NORMAL;
            LV_WIN: begin
              if (winDone) stateNext = ST_PROTECT;
              else begin
                stb.winClr = 1'b0;
                stb.winInc = 1'b1;
              end
            end
            LV_LOW:  stateNext = ST_PROTECT;
            LV_BATT: stateNext = ST_BATTERY;
          endcase
        end
        ST_PROTECT, ST_BATTERY: begin
          if (level == LV_BATT)    stateNext = ST_BATTERY;
          else if (level == LV_OK) stateNext = ST_RECOVER;
          else                     stateNext = ST_PROTECT;
        end
        ST_RECOVER: begin
          if (level == LV_BATT)     stateNext = ST_BATTERY;
          else if (level != LV_OK)  stateNext = ST_PROTECT;
          else if (recDone)         stateNext = ST_NORMAL;
          else begin
            stb.recClr = 1'b0;
            stb.recInc = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PROTECT;
    else       state <= stateNext;
  end

  assign protectOut = (state != ST_NORMAL);
  assign battOut    = (state == ST_BATTERY);

  p_reset_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !flagsValid |-> (protectOut && !battOut));
  p_low_protect_r4: assert property (@(posedge clk) disable iff (!rstN)
    (flagsValid && level == LV_LOW) |=> protectOut);
  p_batt_on_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flagsValid && level == LV_BATT) |=> battOut);
  p_batt_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flagsValid && level != LV_BATT) |=> !battOut);
  p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protectOut) |-> ($past(recDone) && $past(level) == LV_OK));
endmodule

// File: rtl/pwr_fail_guard.sv
module pwr_fail_guard
  import pfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REC_CYCLES  = 1000,
  parameter int DESEL_DELAY = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic aboveHi,
  input  logic aboveLo,
  input  logic aboveSw,
  output logic memProtect,
  output logic battSelect
);
  strobe_t stb;
  level_t  level;
  logic    flagsValid, recDone, winDone;

  pfg_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .REC_CYCLES(REC_CYCLES), .DESEL_DELAY(DESEL_DELAY)
  ) dp_i (
    .clk(clk), .rstN(rstN), .aboveHi(aboveHi), .aboveLo(aboveLo), .aboveSw(aboveSw),
    .stb(stb), .level(level), .flagsValid(flagsValid), .recDone(recDone), .winDone(winDone)
  );

  pfg_control ctl_i (
    .clk(clk), .rstN(rstN), .level(level), .flagsValid(flagsValid),
    .recDone(recDone), .winDone(winDone), .stb(stb),
    .protectOut(memProtect), .battOut(battSelect)
  );

  p_batt_needs_prot_r8: assert property (@(posedge clk) disable iff (!rstN)
    battSelect |-> memProtect);
endmodule

// File: tb/pwr_fail_guard_tb_top.sv
module pwr_fail_guard_tb_top;
  localparam int REC = 20;
  localparam int DEL = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aboveHi = 1'b1, aboveLo = 1'b1, aboveSw = 1'b1;
  logic memProtect, battSelect;

  always #5 clk = ~clk;

  pwr_fail_guard #(.SYNC_STAGES(2), .REC_CYCLES(REC), .DESEL_DELAY(DEL)) dut_i (
    .clk(clk), .rstN(rstN), .aboveHi(aboveHi), .aboveLo(aboveLo), .aboveSw(aboveSw),
    .memProtect(memProtect), .battSelect(battSelect)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  string curReq = "R1";

  // model: 0 normal, 1 protect, 2 battery, 3 recover
  int mState = 1, mRec = 0, mWin = 0;
  logic [2:0] flagQ[$];

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep(logic [2:0] f);
    int lv;
    if (!f[0]) lv = 0; else if (!f[1]) lv = 1; else if (!f[2]) lv = 2; else lv = 3;
    if (mState == 0) begin
      if (lv == 3) mWin = 0;
      else if (lv == 2) begin mWin++; if (mWin >= DEL) begin mState = 1; mWin = 0; end end
      else if (lv == 1) mState = 1;
      else mState = 2;
    end else if (lv == 0) mState = 2;
    else if (lv != 3) mState = 1;
    else if (mState != 3) begin mState = 3; mRec = 0; end
    else begin mRec++; if (mRec >= REC) begin mState = 0; mWin = 0; end end
  endtask

  task automatic tick(logic h, logic l, logic s);
    @(negedge clk);
    check({curReq, " protect"}, memProtect, mState != 0);
    check({curReq, " battery"}, battSelect, mState == 2);
    aboveHi = h; aboveLo = l; aboveSw = s;
    if (rstN) begin
      flagQ.push_back({h, l, s});
      if (flagQ.size() == 3) modelStep(flagQ.pop_front());
    end
  endtask

  task automatic hold(logic h, logic l, logic s, int n, string req);
    curReq = req;
    for (int i = 0; i < n; i++) tick(h, l, s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset protect", memProtect, 1'b1);
    check("R1 reset battery", battSelect, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    flagQ.push_back(3'b111);
    curReq = "R1";
    tick(1, 1, 1); tick(1, 1, 1);
    check("R1 still protected before valid", memProtect, 1'b1);
    hold(1, 1, 1, REC + 5, "R6");
    check("R6 released after recovery", memProtect, 1'b0);
    // R2 latency
    curReq = "R2";
    tick(1, 0, 1); tick(1, 0, 1);
    check("R2 no effect after 1 edge", memProtect, 1'b0);
    tick(1, 0, 1);
    check("R2 no effect after 2 edges", memProtect, 1'b0);
    tick(1, 0, 1);
    check("R2/R4/R7 effect on 3rd edge", memProtect, 1'b1);
    hold(1, 1, 1, REC + 5, "R6");
    // R3 short dip
    hold(0, 1, 1, DEL - 1, "R3");
    hold(1, 1, 1, 6, "R3");
    check("R3 short window dip ignored", memProtect, 1'b0);
    hold(0, 1, 1, DEL + 4, "R3");
    check("R3 long window dip protects", memProtect, 1'b1);
    // R6 restart
    hold(1, 1, 1, REC - 3, "R6");
    hold(0, 1, 1, 1, "R6");
    hold(1, 1, 1, REC, "R6");
    check("R6 restarted recovery still protecting", memProtect, 1'b1);
    hold(1, 1, 1, 8, "R6");
    check("R6 released after full restart", memProtect, 1'b0);
    // R4 single-cycle low
    hold(1, 0, 1, 1, "R4");
    hold(1, 1, 1, 3, "R4");
    check("R4 single low cycle protects", memProtect, 1'b1);
    hold(1, 1, 1, REC + 3, "R6");
    // R5 battery
    hold(0, 0, 0, 8, "R5");
    check("R5 battery selected", battSelect, 1'b1);
    check("R8 protect with battery", memProtect, 1'b1);
    hold(0, 1, 1, 5, "R5");
    check("R5 battery released", battSelect, 1'b0);
    hold(1, 1, 1, REC + 5, "R6");
    // R7 inconsistent combos
    hold(1, 1, 0, 5, "R7");
    check("R7 hi/lo set, sw clear -> battery", battSelect, 1'b1);
    hold(0, 0, 1, 3, "R7");
    hold(1, 1, 1, REC + 5, "R7");
    hold(1, 0, 1, 5, "R7");
    check("R7 hi set, lo clear -> protect", memProtect, 1'b1);
    check("R7 no battery", battSelect, 1'b0);
    hold(1, 1, 1, REC + 5, "R6");
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule